// File: doc/BRIEF.md
# Device Register Address Decoder

This block sits between an asynchronous 18-bit peripheral bus and a small set of device registers. Software sees these registers as a window of four words. The block watches the address lines, the two mode-control lines and the master-sync strobe. It brings them into the local clock domain, then decides two things: whether the address falls inside the window, and which word it names.

It drives four one-hot register selects and three gating strobes. The strobes are a read strobe, a low-byte write strobe and a high-byte write strobe. Downstream register logic combines one select with one strobe to perform a transfer.

The block also returns a slave acknowledge to the bus master after a programmable number of clock cycles. An inhibit input can suppress that acknowledge so that another agent can supply it.

The window base is fixed by a parameter, one bit for each address line from 12 down to 3. Each bit behaves like a solder jumper. Combinations that name an unused register or byte lane complete silently: no strobe fires and no error is raised.

Top module: `regWindowDecoder`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, all outputs are 0.
- R2: The window is hit only when `busAddr[17:13]` are all 1 and each bit of `busAddr[12:3]` equals the inverse of the matching bit of parameter `JUMPER_FIT`. A 1 in `JUMPER_FIT` marks a fitted jumper and requires a 0 on that line. The default of 10'b1000000000 matches word addresses 767770 to 767776 octal. A miss asserts no select and never acknowledges.
- R3: `regSel[k]` asserts for word offset 2k, where k = `busAddr[2:1]`. It asserts only on a hit and while the synchronized master sync is high. At most one select is active at any time.
- R4: Mode encoding on `busMode`:
  - 00 or 01 is a read and asserts `gateIn`.
  - 10 is a word write and asserts both `gateOutLow` and `gateOutHigh`.
  - 11 is a byte write. It asserts `gateOutLow` when `busAddr[0]` is 0 and `gateOutHigh` when `busAddr[0]` is 1.
  - Strobes do not depend on the window hit.
- R5: Some strobes are suppressed by word offset:
  - Offset 4 never asserts a write strobe.
  - Offset 0 never asserts `gateOutHigh`.
  - Offset 6 asserts no strobe at all.
  - Offset 2 allows every strobe.
- R6: No strobe or select is active while the synchronized master sync is low.
- R7: Every bus input passes through `SYNC_STAGES` flops (default 2). Selects and strobes first reflect a change after the second rising clock edge that samples it, and not after the first.
- R8: On a hit without inhibit, `slaveAck` rises exactly `ACK_DELAY` cycles after the selects assert. It stays high while master sync stays high.
- R9: While the synchronized `ackInhibit` is high, `slaveAck` stays low even on a hit.
- R10: When master sync is released, `slaveAck`, the selects and the strobes fall together. This happens after the same synchronizer latency as assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 18 | Bus address lines |
| busMode | input | 2 | Cycle mode-control lines |
| masterSync | input | 1 | Master sync strobe, active high |
| ackInhibit | input | 1 | Suppresses the slave acknowledge |
| regSel | output | 4 | One-hot register select, index = word offset / 2 |
| gateIn | output | 1 | Read strobe |
| gateOutLow | output | 1 | Low-byte write strobe |
| gateOutHigh | output | 1 | High-byte write strobe |
| slaveAck | output | 1 | Delayed slave acknowledge |

## Verification
The assertions check several properties on every cycle:
- the selects stay one-hot;
- the offset restrictions hold, with no write strobe on the input buffer and no high strobe on the status word;
- no select appears without a hit under synchronized master sync;
- the acknowledge is dropped under inhibit or release, and is held while the cycle persists.

Some properties need known stimulus and are shown only by the bench scenarios:
- the exact acknowledge delay;
- the two-edge synchronizer latency;
- the mode decoding;
- the rejection of addresses that miss the upper bits or a single jumper bit.

// File: rtl/regWinPkg.sv
package regWinPkg;
  localparam int ADDR_W = 18;
  localparam int MODE_W = 2;
  localparam int NUM_SEL = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_READ       = 2'b00,
    MODE_READ_HOLD  = 2'b01,
    MODE_WRITE_WORD = 2'b10,
    MODE_WRITE_BYTE = 2'b11
  } busMode_e;

  typedef struct packed {
    logic              inhibit;
    logic              msync;
    logic [MODE_W-1:0] mode;
    logic [ADDR_W-1:0] addr;
  } busSample_t;

  localparam int SAMPLE_W = $bits(busSample_t);

  // Strobes handed from the datapath to the acknowledge control
  typedef struct packed {
    logic msync;
    logic hit;
    logic inhibit;
  } ctlView_t;
endpackage

// File: rtl/syncChain.sv
module syncChain #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stage[i] <= '0;
          else       stage[i] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stage[i] <= '0;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];
endmodule

// File: rtl/winDatapath.sv
module winDatapath
  import regWinPkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [9:0]  JUMPER_FIT  = 10'b10_0000_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [MODE_W-1:0]   busMode,
  input  logic                masterSync,
  input  logic                ackInhibit,
  output logic [NUM_SEL-1:0]  regSel,
  output logic                gateIn,
  output logic                gateOutLow,
  output logic                gateOutHigh,
  output ctlView_t            view
);
  localparam int TOP_LO  = 13;
  localparam int BASE_HI = 12;
  localparam int BASE_LO = 3;
  localparam logic [1:0] OFF_STATUS = 2'd0;
  localparam logic [1:0] OFF_OUTBUF = 2'd1;
  localparam logic [1:0] OFF_INBUF  = 2'd2;
  localparam logic [1:0] OFF_SPARE  = 2'd3;

  busSample_t rawIn, syncd;
  logic topOnes, baseOk, hit;
  logic [1:0] offset;
  logic isRead, isByte, laneLow, laneHigh, lowAllowed, highAllowed;

  assign rawIn = '{inhibit: ackInhibit, msync: masterSync, mode: busMode, addr: busAddr};

  syncChain #(.WIDTH(SAMPLE_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .dIn(rawIn), .dOut(syncd)
  );

  assign topOnes = &syncd.addr[ADDR_W-1:TOP_LO];
  assign baseOk  = (syncd.addr[BASE_HI:BASE_LO] == ~JUMPER_FIT);
  assign hit     = topOnes && baseOk;
  assign offset  = syncd.addr[2:1];

  generate
    for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
      assign regSel[k] = syncd.msync && hit && (offset == 2'(k));
    end
  endgenerate

  always_comb begin
    isRead      = (syncd.mode == MODE_READ) || (syncd.mode == MODE_READ_HOLD);
    isByte      = (syncd.mode == MODE_WRITE_BYTE);
    laneLow     = !isByte || !syncd.addr[0];
    laneHigh    = !isByte ||  syncd.addr[0];
    lowAllowed  = (offset == OFF_STATUS) || (offset == OFF_OUTBUF);
    highAllowed = (offset == OFF_OUTBUF);
    gateIn      = syncd.msync && isRead && (offset != OFF_SPARE);
    gateOutLow  = syncd.msync && !isRead && laneLow && lowAllowed;
    gateOutHigh = syncd.msync && !isRead && laneHigh && highAllowed && (offset != OFF_INBUF);
  end

  assign view = '{msync: syncd.msync, hit: hit, inhibit: syncd.inhibit};
endmodule

// File: rtl/ackControl.sv
module ackControl
  import regWinPkg::*;
#(
  parameter int ACK_DELAY = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctlView_t view,
  output logic     slaveAck
);
  localparam int CNT_W = $clog2(ACK_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(ACK_DELAY);

  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                        waitCnt <= '0;
    else if (!view.msync || !view.hit) waitCnt <= '0;
    else if (waitCnt != CNT_END)       waitCnt <= waitCnt + 1'b1;
  end

  assign slaveAck = view.msync && view.hit && !view.inhibit && (waitCnt == CNT_END);
endmodule

// File: rtl/regWindowDecoder.sv
module regWindowDecoder
  import regWinPkg::*;
#(
  parameter int          ACK_DELAY   = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [9:0]  JUMPER_FIT  = 10'b10_0000_0000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [17:0]  busAddr,
  input  logic [1:0]   busMode,
  input  logic         masterSync,
  input  logic         ackInhibit,
  output logic [3:0]   regSel,
  output logic         gateIn,
  output logic         gateOutLow,
  output logic         gateOutHigh,
  output logic         slaveAck
);
  ctlView_t view;

  winDatapath #(.SYNC_STAGES(SYNC_STAGES), .JUMPER_FIT(JUMPER_FIT)) i_datapath (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busMode(busMode),
    .masterSync(masterSync), .ackInhibit(ackInhibit), .regSel(regSel),
    .gateIn(gateIn), .gateOutLow(gateOutLow), .gateOutHigh(gateOutHigh), .view(view)
  );

  ackControl #(.ACK_DELAY(ACK_DELAY)) i_ackControl (
    .clk(clk), .rstN(rstN), .view(view), .slaveAck(slaveAck)
  );
endmodule

// File: rtl/regWindowChecker.sv
module regWindowChecker
  import regWinPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input ctlView_t   view,
  input logic [3:0] regSel,
  input logic       gateIn,
  input logic       gateOutLow,
  input logic       gateOutHigh,
  input logic       slaveAck
);
  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regSel));

  a_r2_sel_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    (|regSel) |-> (view.msync && view.hit));

  a_r5_inbuf_no_write: assert property (@(posedge clk) disable iff (!rstN)
    regSel[2] |-> !(gateOutLow || gateOutHigh));

  a_r5_status_no_high: assert property (@(posedge clk) disable iff (!rstN)
    regSel[0] |-> !gateOutHigh);

  a_r5_spare_silent: assert property (@(posedge clk) disable iff (!rstN)
    regSel[3] |-> !(gateIn || gateOutLow || gateOutHigh));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !view.msync |-> !(gateIn || gateOutLow || gateOutHigh || (|regSel)));

  a_r9_inhibit_blocks: assert property (@(posedge clk) disable iff (!rstN)
    view.inhibit |-> !slaveAck);

  a_r10_release_drops: assert property (@(posedge clk) disable iff (!rstN)
    !view.msync |-> !slaveAck);

  a_r8_ack_holds: assert property (@(posedge clk) disable iff (!rstN)
    slaveAck |=> (slaveAck || !view.msync || view.inhibit || !view.hit));

  a_r8_ack_after_sync: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slaveAck) |-> $past(view.msync));
endmodule

bind regWindowDecoder regWindowChecker i_checker (
  .clk(clk), .rstN(rstN), .view(view), .regSel(regSel), .gateIn(gateIn),
  .gateOutLow(gateOutLow), .gateOutHigh(gateOutHigh), .slaveAck(slaveAck)
);

// File: tb/test_regWindowDecoder.sv
module test_regWindowDecoder;
  localparam int CLK_PERIOD = 10;
  localparam int ACK_D = 8;
  localparam logic [9:0] JUMP = 10'b10_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [17:0] busAddr = '0;
  logic [1:0] busMode = '0;
  logic masterSync = 1'b0;
  logic ackInhibit = 1'b0;
  logic [3:0] regSel;
  logic gateIn, gateOutLow, gateOutHigh, slaveAck;

  int compared = 0;
  int mismatched = 0;
  int negCount = 0;
  bit done = 1'b0;

  typedef struct {
    int at;
    string tag;
    logic [3:0] sel;
    logic inS, lo, hi, ack;
  } expItem_t;
  expItem_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  regWindowDecoder #(.ACK_DELAY(ACK_D), .SYNC_STAGES(2), .JUMPER_FIT(JUMP)) i_regWindowDecoder (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busMode(busMode),
    .masterSync(masterSync), .ackInhibit(ackInhibit), .regSel(regSel),
    .gateIn(gateIn), .gateOutLow(gateOutLow), .gateOutHigh(gateOutHigh), .slaveAck(slaveAck)
  );

  task automatic compareNow(input expItem_t e);
    bit bad = 1'b0;
    compared++;
    if (regSel !== e.sel) begin
      bad = 1'b1;
      $display("FAIL %s regSel act=%b exp=%b", e.tag, regSel, e.sel);
    end
    if (gateIn !== e.inS) begin
      bad = 1'b1;
      $display("FAIL %s gateIn act=%b exp=%b", e.tag, gateIn, e.inS);
    end
    if (gateOutLow !== e.lo) begin
      bad = 1'b1;
      $display("FAIL %s gateOutLow act=%b exp=%b", e.tag, gateOutLow, e.lo);
    end
    if (gateOutHigh !== e.hi) begin
      bad = 1'b1;
      $display("FAIL %s gateOutHigh act=%b exp=%b", e.tag, gateOutHigh, e.hi);
    end
    if (slaveAck !== e.ack) begin
      bad = 1'b1;
      $display("FAIL %s slaveAck act=%b exp=%b", e.tag, slaveAck, e.ack);
    end
    if (bad) mismatched++;
  endtask

  // Monitor: pops expected items when their sampling negedge arrives
  initial begin
    forever begin
      @(negedge clk);
      negCount++;
      while (q.size() > 0 && q[0].at <= negCount) begin
        expItem_t e;
        e = q.pop_front();
        compareNow(e);
      end
    end
  end

  function automatic expItem_t mk(input int at, input string tag, input logic [3:0] sel,
                                  input logic i, input logic l, input logic h, input logic a);
    expItem_t e;
    e.at = at; e.tag = tag; e.sel = sel; e.inS = i; e.lo = l; e.hi = h; e.ack = a;
    return e;
  endfunction

  // Driver: one bus cycle, expectations derived from the requirements
  task automatic access(input logic [17:0] a, input logic [1:0] m, input logic inh, input string tag);
    logic hit, rd, byteW, expIn, expLo, expHi, expAck;
    logic [1:0] off;
    logic [3:0] expSel;
    int n;
    int r;
    hit    = (&a[17:13]) && (a[12:3] == ~JUMP);
    off    = a[2:1];
    rd     = (m[1] == 1'b0);
    byteW  = (m == 2'b11);
    expIn  = rd && (off != 2'd3);
    expLo  = !rd && (!byteW || !a[0]) && (off == 2'd0 || off == 2'd1);
    expHi  = !rd && (!byteW || a[0]) && (off == 2'd1);
    expSel = hit ? (4'b0001 << off) : 4'b0000;
    expAck = hit && !inh;
    @(negedge clk); #1;
    busAddr = a; busMode = m; ackInhibit = inh; masterSync = 1'b1;
    n = negCount;
    q.push_back(mk(n + 1, {tag, " R7 one edge not enough"}, 4'b0, 0, 0, 0, 0));
    q.push_back(mk(n + 2, {tag, " R3 R4 R5 decode"}, expSel, expIn, expLo, expHi, 1'b0));
    q.push_back(mk(n + 1 + ACK_D, {tag, " R8 ack not early"}, expSel, expIn, expLo, expHi, 1'b0));
    q.push_back(mk(n + 2 + ACK_D, {tag, " R8 R9 ack on time"}, expSel, expIn, expLo, expHi, expAck));
    repeat (ACK_D + 4) @(negedge clk);
    #1;
    masterSync = 1'b0;
    r = negCount;
    q.push_back(mk(r + 1, {tag, " R8 ack held"}, expSel, expIn, expLo, expHi, expAck));
    q.push_back(mk(r + 2, {tag, " R6 R10 release"}, 4'b0, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareNow(mk(0, "R1 in reset", 4'b0, 0, 0, 0, 0));
    rstN = 1'b1;
    @(negedge clk);
    compareNow(mk(0, "R1 after reset", 4'b0, 0, 0, 0, 0));

    access(18'o767770, 2'b00, 1'b0, "R3 read status");
    access(18'o767772, 2'b01, 1'b0, "R4 read-hold outbuf");
    access(18'o767772, 2'b10, 1'b0, "R4 word write outbuf");
    access(18'o767773, 2'b11, 1'b0, "R4 byte write outbuf high");
    access(18'o767770, 2'b11, 1'b0, "R4 byte write status low");
    access(18'o767771, 2'b11, 1'b0, "R5 byte write status high ignored");
    access(18'o767770, 2'b10, 1'b0, "R5 word write status low only");
    access(18'o767774, 2'b10, 1'b0, "R5 write inbuf ignored");
    access(18'o767774, 2'b00, 1'b0, "R3 read inbuf");
    access(18'o767776, 2'b00, 1'b0, "R5 read spare ignored");
    access(18'o767776, 2'b10, 1'b0, "R5 write spare ignored");
    access(18'o757772, 2'b00, 1'b0, "R2 miss upper bit13");
    access(18'o767772 ^ 18'h20, 2'b00, 1'b0, "R2 miss jumper bit5");
    access(18'o767772, 2'b00, 1'b1, "R9 inhibited ack");

    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule